// File: doc/BRIEF.md
# Mode-Programmable GPIO Bank

This block holds sixteen general-purpose pins. Each pin has a 4-bit mode code. The pins are kept in four register groups of uneven size. Software reaches the bank through a command port with a valid/ready handshake. One command does one of four things:

- write mode codes into the pins named by a mask;
- ask which pins currently carry a given mode code;
- write output data into masked pins;
- sample the pad levels.

Every mode code has its own set of pins on which it is legal. A mode request that names even one illegal pin is refused as a whole and changes nothing. A data write that names any pin not in output mode is refused in the same way. A pin drives its pad only while its mode is output.

The register groups hold 2, 4, 4 and 6 pins. Their first global pin indices are 0, 2, 6 and 10. Inside a group, pin i keeps its mode field at bits 4*i+3 down to 4*i. A group is written only when the mask of the command touches it.

Top module: `gpio_mode_bank`

## Requirements
- R1: After reset every pin holds mode 0x0 (input) and data 0. pad_oe and pad_out are all zero, rsp_valid is low, and a query for code 0x0 returns 0xFFFF.
- R2: A set-mode command (cmd_op = 0, code in cmd_arg[3:0]) that is legal writes the code into the mode field of every masked pin and leaves every unmasked pin unchanged. A legal command returns rsp_err = 0 and rsp_data = 0.
- R3: Codes 0x0 and 0x8 are legal on all pins. Code 0x2 is legal on pins 4 and 5 only, code 0x9 on pins 0 to 3 only, and code 0xA on pins 0 and 1 only. All other codes (0x1, 0x3 to 0x7, 0xB to 0xF) are legal on no pin. A set-mode command with an empty mask is always legal.
- R4: A set-mode command whose mask holds any pin that is illegal for its code returns rsp_err = 1, and no mode field changes.
- R5: A query command (cmd_op = 1, code in cmd_arg[3:0]) returns rsp_data in which bit i is 1 exactly when pin i's mode equals the code. It returns rsp_err = 0.
- R6: A data-write command (cmd_op = 2, data in cmd_arg) whose masked pins are all in mode 0x8 loads cmd_arg[i] into data bit i for each masked pin only. It returns rsp_err = 0.
- R7: A data-write command whose mask holds a pin not in mode 0x8 returns rsp_err = 1, and no data bit changes.
- R8: pad_oe[i] is 1 exactly when pin i's mode is 0x8, and pad_out[i] then equals its data bit. In every other mode pad_out[i] is 0. The data bit is kept while the pin is out of output mode.
- R9: A level-read command (cmd_op = 3) returns rsp_data = pad_in & cmd_mask, sampled in the accepting cycle, with rsp_err = 0.
- R10: cmd_ready is high whenever the block is out of reset. An accepted command gives exactly one cycle of rsp_valid = 1 in the following cycle, and the new state is visible on the pads in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 set mode, 1 query mode, 2 write data, 3 read levels |
| cmd_mask | input | 16 | Pin mask, bit i is pin i |
| cmd_arg | input | 16 | Mode code in [3:0], or write data |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 16 | Query match vector or sampled levels |
| pad_in | input | 16 | Pad levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |

## Verification
The hard cases are the refusals that fall on a single illegal pin at the edge of a legal set. Examples are code 0x2 on pin 6 next to legal pins 4 and 5, and code 0xA on pin 2. Another is a data write that crosses from an output group into a group still in input mode.

The stimulus first builds a mixed mode map across all four groups. It then issues requests that differ from a legal one by one pin. After each request it checks that the pads and a later query show no change. To check that data survives a mode change, the bench moves pins out of output mode and back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPINS   = 16;
  localparam int MODE_W  = 4;
  localparam int NGROUPS = 4;
  localparam int OP_W    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_SET_MODE = 2'd0,
    OP_QUERY    = 2'd1,
    OP_WR_DATA  = 2'd2,
    OP_RD_LEVEL = 2'd3
  } bank_op_e;

  localparam logic [MODE_W-1:0] MD_INPUT  = 4'h0;
  localparam logic [MODE_W-1:0] MD_SERIN  = 4'h2;
  localparam logic [MODE_W-1:0] MD_OUTPUT = 4'h8;
  localparam logic [MODE_W-1:0] MD_SEROUT = 4'h9;
  localparam logic [MODE_W-1:0] MD_TMRB   = 4'hA;

  // first global pin of each register group
  function automatic int grp_base(input int g);
    case (g)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      default: return 10;
    endcase
  endfunction

  // number of pins in each register group
  function automatic int grp_count(input int g);
    case (g)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  // pins on which a mode code may be placed
  function automatic logic [NPINS-1:0] legal_pins(input logic [MODE_W-1:0] code);
    case (code)
      MD_INPUT, MD_OUTPUT: return {NPINS{1'b1}};
      MD_SERIN:            return 16'h0030;
      MD_SEROUT:           return 16'h000F;
      MD_TMRB:             return 16'h0003;
      default:             return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_s = stage_q[1];
endmodule

// File: rtl/gpio_pin_group.sv
module gpio_pin_group #(
  parameter int COUNT  = 2,
  parameter int MODE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_mode,
  input  logic                      wr_data,
  input  logic [COUNT-1:0]          mask,
  input  logic [MODE_W-1:0]         code,
  input  logic [COUNT-1:0]          wdata,
  output logic [COUNT-1:0]          match,
  output logic [COUNT-1:0]          is_out,
  output logic [COUNT-1:0]          dout
);
  localparam int FW = COUNT * MODE_W;
  localparam logic [MODE_W-1:0] OUT_CODE = 4'h8;

  logic [FW-1:0]    field_q, field_d;
  logic [COUNT-1:0] data_q, data_d;
  logic             field_en, data_en;

  always_comb begin
    field_en = set_mode && (|mask);
    field_d  = field_q;
    for (int i = 0; i < COUNT; i++) begin
      if (mask[i]) field_d[i*MODE_W +: MODE_W] = code;
    end
  end

  always_comb begin
    data_en = wr_data && (|mask);
    data_d  = (data_q & ~mask) | (wdata & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= '0;
    else if (field_en) field_q <= field_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  for (genvar i = 0; i < COUNT; i++) begin : g_pin
    assign match[i]  = (field_q[i*MODE_W +: MODE_W] == code);
    assign is_out[i] = (field_q[i*MODE_W +: MODE_W] == OUT_CODE);
  end

  assign dout = data_q;
endmodule

// File: rtl/gpio_rule_check.sv
module gpio_rule_check
  import gpio_bank_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [NPINS-1:0]  mask,
  input  logic [MODE_W-1:0] code,
  input  logic [NPINS-1:0]  out_pins,
  output logic              reject
);
  logic [NPINS-1:0] bad_mode, bad_data;

  always_comb begin
    bad_mode = mask & ~legal_pins(code);
    bad_data = mask & ~out_pins;
    case (bank_op_e'(op))
      OP_SET_MODE: reject = |bad_mode;
      OP_WR_DATA:  reject = |bad_data;
      default:     reject = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       cmd_mask,
  input  logic [15:0]       cmd_arg,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [15:0]       rsp_data,
  input  logic [15:0]       pad_in,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_oe
);
  logic              rst_s;
  logic              accept, reject;
  logic              do_set, do_wr;
  logic [MODE_W-1:0] code;
  logic [NPINS-1:0]  match_all, out_all, data_all;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_err_q, rsp_err_d;
  logic [NPINS-1:0]  rsp_data_q, rsp_data_d;

  gpio_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  assign cmd_ready = rst_s;
  assign accept    = cmd_valid && cmd_ready;
  assign code      = cmd_arg[MODE_W-1:0];

  gpio_rule_check u_rule (
    .op       (cmd_op),
    .mask     (cmd_mask),
    .code     (code),
    .out_pins (out_all),
    .reject   (reject)
  );

  assign do_set = accept && !reject && (bank_op_e'(cmd_op) == OP_SET_MODE);
  assign do_wr  = accept && !reject && (bank_op_e'(cmd_op) == OP_WR_DATA);

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int B = grp_base(g);
    localparam int C = grp_count(g);
    gpio_pin_group #(.COUNT(C), .MODE_W(MODE_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_s),
      .set_mode (do_set),
      .wr_data  (do_wr),
      .mask     (cmd_mask[B +: C]),
      .code     (code),
      .wdata    (cmd_arg[B +: C]),
      .match    (match_all[B +: C]),
      .is_out   (out_all[B +: C]),
      .dout     (data_all[B +: C])
    );
  end

  always_comb begin
    rsp_valid_d = accept;
    rsp_err_d   = accept && reject;
    rsp_data_d  = '0;
    if (accept) begin
      case (bank_op_e'(cmd_op))
        OP_QUERY:    rsp_data_d = match_all;
        OP_RD_LEVEL: rsp_data_d = pad_in & cmd_mask;
        default:     rsp_data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;
  assign pad_oe    = out_all;
  assign pad_out   = data_all & out_all;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic        clk,
  input logic        rst_s,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [15:0] cmd_mask,
  input logic [15:0] cmd_arg,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [15:0] rsp_data,
  input logic [15:0] pad_out,
  input logic [15:0] pad_oe
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R4
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && cmd_op == 2'd0 && |(cmd_mask & ~legal_pins(cmd_arg[3:0])))
      |=> (rsp_err && $stable(pad_oe)));

  // R7
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && cmd_op == 2'd2 && |(cmd_mask & ~pad_oe))
      |=> (rsp_err && $stable(pad_out)));

  // R8
  drive_only_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((pad_out & ~pad_oe) == 16'h0000));

  // R10
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    acc |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !acc |=> (!rsp_valid && !rsp_err));

  // R5
  query_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && cmd_op == 2'd1 && cmd_arg[3:0] == 4'h8) |=> (rsp_data == pad_oe));

  // R2
  set_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && cmd_op == 2'd0 && cmd_arg[3:0] == 4'h8)
      |=> ((pad_oe & $past(cmd_mask)) == $past(cmd_mask)));
endmodule

bind gpio_mode_bank gpio_bank_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_mask  (cmd_mask),
  .cmd_arg   (cmd_arg),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/test_gpio_mode_bank.sv
`timescale 1ns/1ps
module test_gpio_mode_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_mask, cmd_arg;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_data, pad_in, pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int mode_m[16];
  bit data_m[16];

  always #2.5 clk = ~clk;

  gpio_mode_bank i_gpio_mode_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [15:0] legal_m(input int code);
    if (code == 0 || code == 8) return 16'hFFFF;
    if (code == 2) return 16'h0030;
    if (code == 9) return 16'h000F;
    if (code == 10) return 16'h0003;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] oe_m();
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) v[i] = (mode_m[i] == 8);
    return v;
  endfunction

  function automatic logic [15:0] out_m();
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) v[i] = (mode_m[i] == 8) && data_m[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pads(input string tag);
    chk({tag, " pad_oe R8"}, pad_oe, oe_m());
    chk({tag, " pad_out R8"}, pad_out, out_m());
  endtask

  // called at a negedge; returns at the next negedge with the response checked
  task automatic run(input logic [1:0] op, input logic [15:0] mask,
                     input logic [15:0] arg, input string tag);
    logic        e_err  = 1'b0;
    logic [15:0] e_data = '0;
    int code = int'(arg[3:0]);
    case (op)
      2'd0: begin
        if ((mask & ~legal_m(code)) != 0) e_err = 1'b1;
        else for (int i = 0; i < 16; i++) if (mask[i]) mode_m[i] = code;
      end
      2'd1: for (int i = 0; i < 16; i++) e_data[i] = (mode_m[i] == code);
      2'd2: begin
        if ((mask & ~oe_m()) != 0) e_err = 1'b1;
        else for (int i = 0; i < 16; i++) if (mask[i]) data_m[i] = arg[i];
      end
      default: e_data = pad_in & mask;
    endcase
    chk({tag, " cmd_ready R10"}, {15'd0, cmd_ready}, 16'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_mask = mask; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " rsp_valid R10"}, {15'd0, rsp_valid}, 16'd1);
    chk({tag, " rsp_err"}, {15'd0, rsp_err}, {15'd0, e_err});
    chk({tag, " rsp_data"}, rsp_data, e_data);
    chk_pads(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk({tag, " idle rsp_valid R10"}, {15'd0, rsp_valid}, 16'd0);
    chk_pads(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_mask = '0; cmd_arg = '0;
    pad_in = 16'h0000;
    for (int i = 0; i < 16; i++) begin mode_m[i] = 0; data_m[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid in reset", {15'd0, rsp_valid}, 16'd0);
    chk("R1 pad_oe in reset", pad_oe, 16'h0000);
    chk("R1 pad_out in reset", pad_out, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(2'd1, 16'hFFFF, 16'h0000, "R1 query input after reset");
    run(2'd1, 16'hFFFF, 16'h0008, "R1 query output after reset");

    // R2 legal set, unmasked pins untouched
    run(2'd0, 16'h00F0, 16'h0008, "R2 set output 4..7");
    run(2'd1, 16'hFFFF, 16'h0008, "R2 query output");
    run(2'd1, 16'hFFFF, 16'h0000, "R2 query input");
    idle("R2");

    // R3 legality table, R4 refusals
    run(2'd0, 16'h0030, 16'h0002, "R3 serial-in on 4,5");
    run(2'd0, 16'h0070, 16'h0002, "R4 serial-in touching pin 6");
    run(2'd0, 16'h000F, 16'h0009, "R3 serial-out on 0..3");
    run(2'd0, 16'h0018, 16'h0009, "R4 serial-out touching pin 4");
    run(2'd0, 16'h0004, 16'h000A, "R4 timer-b on pin 2");
    run(2'd0, 16'h0003, 16'h000A, "R3 timer-b on 0,1");
    run(2'd0, 16'h0001, 16'h0001, "R4 reserved code 1");
    run(2'd0, 16'h8000, 16'h0005, "R4 reserved code 5");
    run(2'd0, 16'h0100, 16'h000B, "R4 unknown code B");
    run(2'd0, 16'h0000, 16'h0007, "R3 empty mask legal");
    run(2'd1, 16'hFFFF, 16'h000A, "R5 query timer-b");
    run(2'd1, 16'hFFFF, 16'h0009, "R5 query serial-out");
    run(2'd1, 16'hFFFF, 16'h0002, "R5 query serial-in");
    run(2'd1, 16'hFFFF, 16'h0008, "R5 query output");

    // R6 data writes, R7 refusals
    run(2'd0, 16'hFC00, 16'h0008, "R2 set output 10..15");
    run(2'd2, 16'hFCC0, 16'hAAAA, "R6 write output pins");
    run(2'd2, 16'h0C00, 16'h5555, "R6 masked subset write");
    run(2'd2, 16'h0300, 16'hFFFF, "R7 write into input group");
    run(2'd2, 16'h0001, 16'hFFFF, "R7 write timer pin");
    run(2'd2, 16'h0000, 16'hFFFF, "R6 empty mask write");
    idle("R6");

    // R8 drive follows mode, data retained
    run(2'd0, 16'hFC00, 16'h0000, "R8 output back to input");
    run(2'd0, 16'h3C00, 16'h0008, "R8 output again");
    run(2'd0, 16'hFFFF, 16'h0008, "R8 all output");
    run(2'd2, 16'hFFFF, 16'h1234, "R6 full write");

    // R9 level reads
    pad_in = 16'hBEEF;
    run(2'd3, 16'hFFFF, 16'h0000, "R9 read all");
    pad_in = 16'h0F0F;
    run(2'd3, 16'h00FF, 16'h0000, "R9 read masked");
    run(2'd3, 16'h0000, 16'h0000, "R9 read empty mask");
    idle("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule